// File: doc/BRIEF.md
# Fully Associative Read Cache with Hit-Advanced Replacement Pointer

This block is a read-only cache for 32-bit byte addresses. It holds 64 lines of 32 bytes each. It has no index field: the upper 27 address bits form the tag, and that tag is compared against every valid line at once, with one comparator per line. A hit returns the addressed 32-bit word from the matching line. A miss sends the block address out on a fill request channel. The block then stalls until eight words arrive on a fill data channel, one word per accepted beat. The refilled line then answers the original request.

Every data path is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a new request waits until the previous response has been taken. The response, the fill request and the fill data each move on a cycle where their valid and ready are both high. The side that raises valid must hold it, with its payload unchanged, until that transfer happens.

The victim line is picked in two ways. While any line is still invalid, a miss fills the lowest-numbered invalid line. Once every line is valid, the miss fills the line named by a single rotating pointer. The pointer steps to the next line (63 wraps to 0) only when a hit lands on the line it names. Refills never move it.

Top module: `assoc_rd_cache`

## Requirements
- R1: After reset every line is invalid and the pointer names line 0. `req_ready` is 1, and `rsp_valid`, `fill_req_valid` and `fill_ready` are 0.
- R2: The tag is address bits [31:5] and the word select is bits [4:2]. Bits [1:0] have no effect on hit detection or returned data.
- R3: A miss raises `fill_req_valid` one cycle after the request is accepted, with `fill_req_addr` equal to the request address with bits [4:0] cleared. The request and its address are held until `fill_req_ready`. `req_ready` stays 0 until the response is taken.
- R4: After the fill request is accepted, `fill_ready` is 1 until eight words have been accepted. The k-th accepted word (k = 0..7) becomes the word at byte offset 4k of the line.
- R5: After the eighth fill word is accepted, `rsp_valid` rises in the next cycle with the requested word. Later requests to that block hit and raise no fill request.
- R6: A hit raises `rsp_valid` in the cycle after acceptance, carrying the word from the matching line, and raises no fill request.
- R7: While any line is invalid, a miss fills the lowest-numbered invalid line.
- R8: When all lines are valid, a miss fills the line the pointer names. A refill leaves the pointer unchanged.
- R9: The pointer advances by one, wrapping from 63 to 0, exactly when an accepted request hits the line it names. Otherwise it holds.
- R10: At most one valid line matches any tag.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Byte address of the word to read |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 32 | Word read from the cache |
| fill_req_valid | output | 1 | Block fetch requested |
| fill_req_ready | input | 1 | Memory side accepts the fetch request |
| fill_req_addr | output | 32 | Block-aligned address to fetch |
| fill_valid | input | 1 | Fill word present |
| fill_ready | output | 1 | Block accepts a fill word |
| fill_data | input | 32 | Fill word, lowest offset first |

## Verification
The bench loads all 64 lines from a cold cache. If the invalid-first rule were broken, earlier lines would be overwritten, and the full re-read sweep that follows would miss. That sweep hits each line in order, so the pointer should walk all the way round and wrap back to line 0. A design with a wrong wrap, or one that moves the pointer on every hit, would then evict the wrong line on the next miss. The bench then probes eviction by alternating misses and hits on and off the pointer's line. A design that moves the pointer on a refill, or that ignores a hit on its line, would turn an expected miss into a hit or the reverse. Back-pressure on the fill request, gaps in the fill stream and a stalled response check that payloads hold and that words land at the right offsets. A design that did otherwise would return shifted or stale data.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FREQ = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/assoc_tag_cam.sv
module assoc_tag_cam #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [TAG_W-1:0]   tag_mem [ENTRIES],
  input  logic [TAG_W-1:0]   probe_tag,
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [IDX_W-1:0]   match_idx
);
  // one comparator per line, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tag_mem[g] == probe_tag);
  end

  assign any_match = |match_vec;

  // OR-encoder: exact when at most one bit is set
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
    end
  end

  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec))
    else $error("multiple lines match one tag");
endmodule

// File: rtl/assoc_victim_ptr.sv
module assoc_victim_ptr #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   victim_idx,
  output logic [IDX_W-1:0]   ptr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered invalid line
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;
  assign ptr_idx    = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (touch && (touch_idx == ptr_q)) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // R9
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |->
      ($past(touch) && ($past(touch_idx) == $past(ptr_q)) &&
       (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))))
    else $error("pointer moved without a hit on its line");
endmodule

// File: rtl/assoc_block_ram.sv
module assoc_block_ram #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WPB     = 8,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned WSEL_W  = $clog2(WPB)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_entry,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_entry,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned DEPTH = ENTRIES * WPB;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wr_entry, wr_word}] <= wr_data;
  end

  assign rd_data = mem[{rd_entry, rd_word}];
endmodule

// File: rtl/assoc_rd_cache.sv
module assoc_rd_cache
  import assoc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned BLOCK_BYTES = 32,
  parameter int unsigned ENTRIES     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [WORD_W-1:0] fill_data
);
  localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
  localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES);
  localparam int unsigned WPB    = BLOCK_BYTES / (WORD_W / 8);
  localparam int unsigned WSEL_W = $clog2(WPB);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPB - 1);

  ctl_state_e        state_q;
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [TAG_W-1:0]  cur_tag_q;
  logic [WSEL_W-1:0] cur_word_q;
  logic [WSEL_W-1:0] beat_q;
  logic [IDX_W-1:0]  vic_q;
  logic [WORD_W-1:0] rsp_q;

  logic [TAG_W-1:0]   in_tag;
  logic [WSEL_W-1:0]  in_word;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   match_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   ptr_idx;
  logic [WORD_W-1:0]  ram_rdata;
  logic               accept;
  logic               hit_acc;
  logic               beat_acc;
  logic               last_beat;

  assign in_tag  = req_addr[ADDR_W-1:OFF_W];
  assign in_word = req_addr[OFF_W-1:BSEL_W];

  assign req_ready      = (state_q == ST_IDLE);
  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_data       = rsp_q;
  assign fill_req_valid = (state_q == ST_FREQ);
  assign fill_req_addr  = {cur_tag_q, {OFF_W{1'b0}}};
  assign fill_ready     = (state_q == ST_FILL);

  assign accept    = req_valid && req_ready;
  assign hit_acc   = accept && any_match;
  assign beat_acc  = fill_valid && fill_ready;
  assign last_beat = beat_acc && (beat_q == LAST_BEAT);

  assoc_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_q),
    .tag_mem   (tag_q),
    .probe_tag (in_tag),
    .match_vec (match_vec),
    .any_match (any_match),
    .match_idx (match_idx)
  );

  assoc_victim_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_q),
    .touch      (hit_acc),
    .touch_idx  (match_idx),
    .victim_idx (victim_idx),
    .ptr_idx    (ptr_idx)
  );

  assoc_block_ram #(.ENTRIES(ENTRIES), .WPB(WPB), .WORD_W(WORD_W),
                    .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_ram (
    .clk      (clk),
    .we       (beat_acc),
    .wr_entry (vic_q),
    .wr_word  (beat_q),
    .wr_data  (fill_data),
    .rd_entry (match_idx),
    .rd_word  (in_word),
    .rd_data  (ram_rdata)
  );

  // control and valid bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (any_match) begin
              state_q <= ST_RESP;
            end else begin
              valid_q[victim_idx] <= 1'b0;
              state_q <= ST_FREQ;
            end
          end
        end
        ST_FREQ: begin
          if (fill_req_ready) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat_acc) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) begin
              valid_q[vic_q] <= 1'b1;
              state_q <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      cur_tag_q  <= in_tag;
      cur_word_q <= in_word;
      vic_q      <= victim_idx;
      if (any_match) rsp_q <= ram_rdata;
    end
    if (beat_acc && (beat_q == cur_word_q)) rsp_q <= fill_data;
    if (last_beat) tag_q[vic_q] <= cur_tag_q;
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)))
    else $error("response changed under back-pressure");

  // R3
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)))
    else $error("fill request dropped or changed before acceptance");

  // R6
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && any_match) |=> (rsp_valid && !fill_req_valid))
    else $error("hit did not respond in the next cycle");

  // R5
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && (beat_q == LAST_BEAT)) |=> (rsp_valid && !fill_ready))
    else $error("last fill word did not lead to a response");

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid || fill_ready) |-> !req_ready)
    else $error("request accepted while a miss is outstanding");
endmodule

// File: tb/assoc_rd_cache_tb.sv
module assoc_rd_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        fill_req_valid;
  logic        fill_req_ready = 1'b0;
  logic [31:0] fill_req_addr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [31:0] fill_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assoc_rd_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return {wa[15:0], wa[31:16]} ^ 32'hC3A5_1E0F ^ (wa * 32'd2654435761);
  endfunction

  function automatic logic [31:0] baddr(input int b);
    return 32'h1000_0000 + 32'(b) * 32'h40;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one complete read; hold > 0 adds back-pressure and fill gaps
  task automatic access(input logic [31:0] a, input bit exp_miss, input int hold,
                        input string rq);
    logic [31:0] blk;
    logic [31:0] expd;
    bit missed;
    blk    = {a[31:5], 5'b0};
    expd   = mem_word(blk + {27'b0, a[4:2], 2'b0});
    missed = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (fill_req_valid) begin
      missed = 1'b1;
      chk(!req_ready, {rq, " R3 req_ready low during miss"}, 32'(req_ready), 0);
      chk(fill_req_addr == blk, {rq, " R3 fill address"}, fill_req_addr, blk);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(fill_req_valid && fill_req_addr == blk, {rq, " R3 request held"},
            fill_req_addr, blk);
      end
      fill_req_ready = 1'b1;
      @(negedge clk);
      fill_req_ready = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (hold > 0 && k == 3) begin
          fill_valid = 1'b0;
          for (int h = 0; h < hold; h++) @(negedge clk);
        end
        chk(fill_ready, {rq, " R4 fill_ready during fill"}, 32'(fill_ready), 1);
        fill_valid = 1'b1;
        fill_data  = mem_word(blk + 32'(4 * k));
        @(negedge clk);
      end
      fill_valid = 1'b0;
      chk(rsp_valid, {rq, " R5 response after last word"}, 32'(rsp_valid), 1);
    end else begin
      chk(rsp_valid, {rq, " R6 hit response next cycle"}, 32'(rsp_valid), 1);
    end
    chk(missed == exp_miss, {rq, " miss/hit outcome (1=miss)"}, 32'(missed), 32'(exp_miss));
    chk(rsp_data == expd, {rq, " read data"}, rsp_data, expd);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == expd, {rq, " R11 response held"}, rsp_data, expd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {rq, " response retired"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    logic [31:0] n1;
    logic [31:0] n2;
    n1 = 32'h2000_0000;
    n2 = 32'h2000_1000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !fill_req_valid && !fill_ready,
        "R1 idle outputs after reset",
        {28'b0, req_ready, rsp_valid, fill_req_valid, fill_ready}, 32'h8);

    // R7 cold loads: each must go to the next free line, all kept
    for (int b = 0; b < 64; b++)
      access(baddr(b) + 32'(((b % 8) * 4) + (b % 4)), 1'b1, 0, "R7 cold load");

    // R2 R5 R9 full re-read: all hit, pointer walks round and wraps to 0
    for (int b = 0; b < 64; b++)
      access(baddr(b) + 32'((((b + 3) % 8) * 4) + ((b + 1) % 4)), 1'b0, 0,
             "R2 R5 R9 re-read sweep");

    // hit away from the pointer leaves it at line 0
    access(baddr(5) + 32'h8, 1'b0, 0, "R9 hit off pointer");
    // R8 full cache: miss replaces line 0 (block 0), with back-pressure
    access(n1 + 32'h14, 1'b1, 2, "R8 first eviction");
    access(baddr(63) + 32'h1C, 1'b0, 0, "R8 line 63 kept");
    access(baddr(1) + 32'h4, 1'b0, 0, "R8 line 1 kept");
    access(baddr(0) + 32'h0, 1'b1, 0, "R8 block 0 was evicted");
    access(n1 + 32'h18, 1'b1, 0, "R8 refill did not move pointer");
    // R9 hit on pointer line moves it to line 1
    access(n1 + 32'h3, 1'b0, 0, "R9 hit on pointer line");
    access(n2 + 32'hC, 1'b1, 3, "R9 eviction at line 1");
    access(n1 + 32'h10, 1'b0, 0, "R9 line 0 kept");
    access(baddr(2) + 32'h1E, 1'b0, 0, "R9 line 2 kept");
    access(baddr(1) + 32'h8, 1'b1, 0, "R9 block 1 was evicted");
    access(n2 + 32'h0, 1'b1, 1, "R8 R9 pointer still at line 1");
    // R2 low bits ignored
    access(n2 + 32'h1, 1'b0, 0, "R2 byte bits ignored a");
    access(n2 + 32'h2, 1'b0, 0, "R2 byte bits ignored b");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule